// File: doc/BRIEF.md
# Capture Compare PWM Timer

A 16-bit counter block for timing work inside a larger chip. It counts either on an internal enable from an 8-bit prescaler or on rising edges of an external clock pin. The external pin is resynchronized to the system clock. Two capture channels store the count when their input pin shows a chosen edge. Two compare channels react when the count reaches their programmed values. A mode field picks between three behaviours: free running with toggling compare outputs, PWM, and a one-shot pulse started by a trigger input.

Five event flags record captures, compare matches and counter wrap. A write-one-to-clear pulse clears the flags. Each flag has its own enable, and the enabled flags are ORed into a single interrupt line. All configuration arrives as plain level inputs. There is no bus port and no data stream, so no valid/ready handshake exists and no back-pressure rules apply.

Top module: `ccpt_timer`

## Requirements
- R1: While reset is asserted and right after it is released, the count is 0, both compare outputs are low, both capture registers hold 0, all flags are 0 and the interrupt is low.
- R2: With clock select 0, the counter advances once every prescale+1 system clocks, so prescale 0 advances it on every clock.
- R3: With clock select 1, the counter advances once for each rising edge of the external pin after two-flop synchronization. The pin must stay high and stay low for at least two system clocks each time, which limits it to a quarter of the system rate. A pin that is held high adds only one count.
- R4: Capture channel k stores the count and sets its flag on the edge picked by edge-select bit k (0 = rising, 1 = falling). The other edge leaves both the register and the flag unchanged.
- R5: The counter wraps from 0xFFFF to 0 and sets flag bit 4 (overflow) when it does so.
- R6: In mode 0 (free run; mode 3 behaves the same), compare output k toggles and compare flag k is set each time the counter takes the value of compare register k.
- R7: In mode 1 (PWM), the counter restarts at 0 on the tick after it has reached compare 1 or more. Output 0 is high while the count is below compare 2. Output 1 stays low. One period is (compare1+1)·(prescale+1) clocks, and the output is high for min(compare2, compare1+1)·(prescale+1) clocks of it.
- R8: In mode 2 (one-pulse), the counter is held at 0 while idle. A rising edge on the trigger (synchronized) starts a run. Output 0 is high while compare1 ≤ count < compare2. On the tick where the count equals compare 2, the run ends and the count returns to 0. Triggers that arrive during a run are ignored. Output 1 stays low.
- R9: The flag bits are: 0 capture 1, 1 capture 2, 2 compare 1, 3 compare 2, 4 overflow. A 1 on a clear bit clears that flag on the next clock. A new event in the same cycle wins over the clear.
- R10: The interrupt is high exactly when some flag is set and its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External count source (asynchronous) |
| cap_pin_i | input | 2 | Capture input pins, bit 0 = channel 1 |
| trig_i | input | 1 | One-pulse trigger (asynchronous) |
| clk_sel_i | input | 1 | 0 = prescaled internal, 1 = external pin |
| prescale_i | input | 8 | Prescaler divide value minus one |
| cap_edge_i | input | 2 | Per-channel edge select, 0 rising / 1 falling |
| mode_i | input | 2 | 0 free run, 1 PWM, 2 one-pulse, 3 free run |
| cmp1_i | input | 16 | Compare 1 value (PWM period, pulse start) |
| cmp2_i | input | 16 | Compare 2 value (PWM duty, pulse end) |
| irq_en_i | input | 5 | Per-flag interrupt enables |
| flag_clr_i | input | 5 | Write-one-to-clear pulses for flags |
| cmp_o | output | 2 | Compare / waveform outputs |
| cap1_o | output | 16 | Capture register 1 |
| cap2_o | output | 16 | Capture register 2 |
| flags_o | output | 5 | Event flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The PWM waveform is measured over a whole number of periods for several sets of prescale, period and duty. The sets include zero duty and a duty longer than the period. The high-time count and the rising-edge count together separate a wrong prescale rate, an off-by-one period and a wrong duty comparison. The counter is stepped one count at a time with external-clock pulses, so capture values and compare matches land on known counts. This shows whether each edge-select and toggle acts on the right edge and the right value. The one-pulse mode is fired once cleanly and once with a retrigger in the middle of the run, which shows whether the run is extended by the retrigger or ignores it.

// File: rtl/ccpt_pkg.sv
package ccpt_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_PWM  = 2'd1,
    MODE_ONE  = 2'd2,
    MODE_ALT  = 2'd3
  } mode_e;

  localparam int NCH      = 2;
  localparam int FLG_CAP0 = 0;
  localparam int FLG_CMP0 = FLG_CAP0 + NCH;
  localparam int FLG_OVF  = FLG_CMP0 + NCH;
  localparam int NFLAG    = FLG_OVF + 1;
endpackage

// File: rtl/ccpt_tick.sv
module ccpt_tick #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_i,
  input  logic             sel_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pcnt;
  logic [2:0]       es;   // es[0], es[1] synchronizer, es[2] edge history

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      es   <= '0;
    end else begin
      es <= {es[1:0], ext_i};
      if (sel_i || pcnt >= pre_i) pcnt <= '0;
      else                        pcnt <= pcnt + 1'b1;
    end
  end

  assign tick_o = sel_i ? (es[1] & ~es[2]) : (pcnt >= pre_i);

  // external edge detector can never fire on two consecutive cycles
  assert_ext_one_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && tick_o) |=> (!tick_o || !sel_i))
    else $error("external tick repeated");

  // a nonzero prescale leaves a gap after every internal tick
  assert_prescale_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i && tick_o && pre_i != '0) |=> (!tick_o || sel_i || pre_i != $past(pre_i)))
    else $error("prescaled tick without gap");
endmodule

// File: rtl/ccpt_capture.sv
module ccpt_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             evt_o
);
  logic [2:0] ps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps    <= '0;
      cap_o <= '0;
    end else begin
      ps <= {ps[1:0], pin_i};
      if (evt_o) cap_o <= cnt_i;
    end
  end

  assign evt_o = fall_i ? (~ps[1] & ps[2]) : (ps[1] & ~ps[2]);

  assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> (cap_o == $past(cnt_i)))
    else $error("capture register missed the count");
endmodule

// File: rtl/ccpt_core.sv
module ccpt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic             trig_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       out_o,
  output logic [1:0]       match_o,
  output logic             ovf_o
);
  import ccpt_pkg::*;

  mode_e            mode;
  logic [CNT_W-1:0] cnt, nxt;
  logic             run, counting, trig_edge;
  logic [2:0]       ts;
  logic [1:0]       tog;

  assign mode      = mode_e'(mode_i);
  assign trig_edge = ts[1] & ~ts[2];

  always_comb begin
    counting = tick_i;
    nxt      = cnt + 1'b1;
    case (mode)
      MODE_PWM: if (cnt >= cmp_a_i) nxt = '0;
      MODE_ONE: begin
        counting = tick_i & run;
        if (cnt == cmp_b_i) nxt = '0;
      end
      default: ;
    endcase
  end

  assign match_o[0] = counting && (nxt == cmp_a_i);
  assign match_o[1] = counting && (nxt == cmp_b_i);
  assign ovf_o      = counting && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
      ts  <= '0;
      tog <= '0;
    end else begin
      ts <= {ts[1:0], trig_i};
      if (mode == MODE_ONE && !run) cnt <= '0;
      else if (counting)            cnt <= nxt;
      if (mode != MODE_ONE)                    run <= 1'b0;
      else if (!run && trig_edge)              run <= 1'b1;
      else if (run && tick_i && cnt == cmp_b_i) run <= 1'b0;
      if (mode == MODE_FREE || mode == MODE_ALT) tog <= tog ^ match_o;
    end
  end

  always_comb begin
    case (mode)
      MODE_PWM: out_o = {1'b0, cnt < cmp_b_i};
      MODE_ONE: out_o = {1'b0, run && cnt >= cmp_a_i && cnt < cmp_b_i};
      default:  out_o = tog;
    endcase
  end

  assign cnt_o = cnt;

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FREE && tick_i && cnt == {CNT_W{1'b1}}) |=> (cnt == '0))
    else $error("counter did not wrap to zero");

  assert_toggle_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FREE && match_o[0] && $past(mode) == MODE_FREE)
      |=> (out_o[0] != $past(out_o[0])))
    else $error("compare output did not toggle");

  assert_pwm_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM && tick_i && cnt >= cmp_a_i) |=> (cnt == '0))
    else $error("PWM period restart missed");

  assert_pulse_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ONE && !run && !trig_edge) |=> (cnt == '0 && !out_o[0]))
    else $error("one-pulse idle not quiet");
endmodule

// File: rtl/ccpt_timer.sv
module ccpt_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ext_clk_i,
  input  logic [1:0]                 cap_pin_i,
  input  logic                       trig_i,
  input  logic                       clk_sel_i,
  input  logic [PRE_W-1:0]           prescale_i,
  input  logic [1:0]                 cap_edge_i,
  input  logic [1:0]                 mode_i,
  input  logic [CNT_W-1:0]           cmp1_i,
  input  logic [CNT_W-1:0]           cmp2_i,
  input  logic [ccpt_pkg::NFLAG-1:0] irq_en_i,
  input  logic [ccpt_pkg::NFLAG-1:0] flag_clr_i,
  output logic [1:0]                 cmp_o,
  output logic [CNT_W-1:0]           cap1_o,
  output logic [CNT_W-1:0]           cap2_o,
  output logic [ccpt_pkg::NFLAG-1:0] flags_o,
  output logic                       irq_o
);
  import ccpt_pkg::*;

  logic                  tick, ovf;
  logic [CNT_W-1:0]      cnt;
  logic [NCH-1:0]        cap_evt, match;
  logic [CNT_W-1:0]      cap_q [NCH];
  logic [NFLAG-1:0]      flag_set, flags_q;

  ccpt_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_i(ext_clk_i), .sel_i(clk_sel_i),
    .pre_i(prescale_i), .tick_o(tick)
  );

  ccpt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode_i),
    .cmp_a_i(cmp1_i), .cmp_b_i(cmp2_i), .trig_i(trig_i),
    .cnt_o(cnt), .out_o(cmp_o), .match_o(match), .ovf_o(ovf)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_cap
    ccpt_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i[k]), .fall_i(cap_edge_i[k]),
      .cnt_i(cnt), .cap_o(cap_q[k]), .evt_o(cap_evt[k])
    );
  end

  assign flag_set = {ovf, match, cap_evt};

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr_i) | flag_set;
  end

  assign cap1_o  = cap_q[0];
  assign cap2_o  = cap_q[1];
  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & irq_en_i);

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag_chk
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i[k] && !flag_set[k]) |=> !flags_q[k])
      else $error("flag survived its clear");
    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[k] |=> flags_q[k])
      else $error("event did not set its flag");
  end
endmodule

// File: tb/tb_ccpt_timer.sv
module tb_ccpt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0, trig = 1'b0, clk_sel = 1'b0;
  logic [1:0]  cap_pin = '0, cap_edge = '0, mode = '0;
  logic [7:0]  prescale = '0;
  logic [15:0] cmp1 = '0, cmp2 = '0;
  logic [4:0]  irq_en = '0, flag_clr = '0;
  logic [1:0]  cmp_o;
  logic [15:0] cap1, cap2;
  logic [4:0]  flags;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccpt_timer dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .cap_pin_i(cap_pin), .trig_i(trig),
    .clk_sel_i(clk_sel), .prescale_i(prescale), .cap_edge_i(cap_edge), .mode_i(mode),
    .cmp1_i(cmp1), .cmp2_i(cmp2), .irq_en_i(irq_en), .flag_clr_i(flag_clr),
    .cmp_o(cmp_o), .cap1_o(cap1), .cap2_o(cap2), .flags_o(flags), .irq_o(irq)
  );

  // {prescale, compare1 (period), compare2 (duty), high clocks per period}
  localparam int NV = 5;
  localparam logic [55:0] VEC [NV] = '{
    {8'd0, 16'd9, 16'd3, 16'd3},
    {8'd1, 16'd4, 16'd2, 16'd4},
    {8'd3, 16'd7, 16'd0, 16'd0},
    {8'd0, 16'd5, 16'd6, 16'd6},
    {8'd2, 16'd3, 16'd1, 16'd3}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic ext_pulse();
    @(negedge clk) ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_flags(input logic [4:0] m);
    @(negedge clk) flag_clr = m;
    @(negedge clk) flag_clr = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // ---- PWM vector table (R7, R2)
    int hi, rises, p, exp_hi, exp_r;
    logic prev;
    clk_sel = 1'b1; cmp1 = 16'd7; cmp2 = 16'd9;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmp_o == 2'b00, "R1", "cmp_o in reset", cmp_o, 0);
    chk(flags == 5'd0 && !irq, "R1", "flags/irq in reset", flags, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cap1 == 0 && cap2 == 0, "R1", "captures after reset", cap1 + cap2, 0);

    // R3: five external pulses -> count 5, then capture on rising edge (R4)
    repeat (5) ext_pulse();
    cap_edge = 2'b10;
    @(negedge clk) cap_pin[0] = 1'b1;
    repeat (6) @(negedge clk);
    chk(cap1 == 16'd5, "R3", "count after 5 ext pulses via capture 1", cap1, 5);
    chk(flags[0], "R4", "capture 1 flag", flags[0], 1);
    // R4: channel 2 set to falling, rising edge ignored
    cap_pin[1] = 1'b1;
    repeat (6) @(negedge clk);
    chk(!flags[1] && cap2 == 0, "R4", "rising edge ignored on falling channel", cap2, 0);
    cap_pin[1] = 1'b0;
    repeat (6) @(negedge clk);
    chk(cap2 == 16'd5 && flags[1], "R4", "falling-edge capture 2", cap2, 5);

    // R9: clear flag 0 only
    clear_flags(5'b00001);
    chk(flags == 5'b00010, "R9", "write-one-to-clear bit 0", flags, 2);
    // R10
    irq_en = 5'b00001;
    @(negedge clk);
    chk(!irq, "R10", "irq masked flag", irq, 0);
    irq_en = 5'b00010;
    @(negedge clk);
    chk(irq, "R10", "irq enabled flag", irq, 1);
    irq_en = '0;

    // R6: two more pulses reach compare 1 = 7 (toggle once), two more reach 9
    repeat (2) ext_pulse();
    chk(cmp_o == 2'b01, "R6", "toggle at compare 1", cmp_o, 1);
    repeat (2) ext_pulse();
    chk(cmp_o == 2'b11, "R6", "toggle at compare 2", cmp_o, 3);
    chk(flags == 5'b01110, "R9", "compare flag bits 2 and 3", flags, 14);

    // R5: internal clock, prescale 0, count from 9 wraps after 65527 clocks
    clear_flags(5'b11111);
    clk_sel = 1'b0; prescale = 8'd0;
    repeat (65000) @(negedge clk);
    chk(!flags[4], "R5", "no overflow before wrap", flags[4], 0);
    repeat (1000) @(negedge clk);
    chk(flags[4], "R5", "overflow flag after wrap", flags[4], 1);

    mode = 2'd1;
    for (int i = 0; i < NV; i++) begin
      prescale = VEC[i][55:48];
      cmp1     = VEC[i][47:32];
      cmp2     = VEC[i][31:16];
      p        = (int'(cmp1) + 1) * (int'(prescale) + 1);
      exp_hi   = 4 * int'(VEC[i][15:0]);
      exp_r    = (VEC[i][15:0] > 0 && int'(VEC[i][15:0]) < p) ? 4 : 0;
      repeat (3 * p + 5) @(negedge clk);
      prev = cmp_o[0]; hi = 0; rises = 0;
      for (int c = 0; c < 4 * p; c++) begin
        @(negedge clk);
        if (cmp_o[0]) hi++;
        if (cmp_o[0] && !prev) rises++;
        if (cmp_o[1]) hi = hi + 1000;
        prev = cmp_o[0];
      end
      chk(hi == exp_hi, "R7", $sformatf("PWM high clocks vector %0d", i), hi, exp_hi);
      chk(rises == exp_r, "R2", $sformatf("PWM period count vector %0d", i), rises, exp_r);
    end

    // ---- R8 one-pulse
    mode = 2'd2; prescale = 8'd0; cmp1 = 16'd3; cmp2 = 16'd8; trig = 1'b0;
    repeat (6) @(negedge clk);
    chk(cmp_o == 2'b00, "R8", "idle output low", cmp_o, 0);
    hi = 0;
    for (int c = 0; c < 30; c++) begin
      if (c == 0) trig = 1'b1;
      if (c == 4) trig = 1'b0;
      if (c == 5) trig = 1'b1;
      @(negedge clk);
      if (cmp_o[0]) hi++;
      if (cmp_o[1]) hi = hi + 1000;
    end
    chk(hi == 5, "R8", "pulse width with retrigger in run", hi, 5);
    trig = 1'b0;
    repeat (5) @(negedge clk);
    hi = 0;
    for (int c = 0; c < 30; c++) begin
      if (c == 0) trig = 1'b1;
      @(negedge clk);
      if (cmp_o[0]) hi++;
    end
    chk(hi == 5, "R8", "second trigger gives a fresh pulse", hi, 5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule